// File: doc/BRIEF.md
# Time-Base Divider with Tone Output

This block is a free-running divider chain that produces a slow periodic tick, a faster periodic tick of selectable period, and a square-wave tone for a buzzer. The chain advances on one of three sources. The first is a strobe from a 32.768 kHz sub-clock domain. The second is every cycle of the system clock. The third is a strobe from the prescaler of another timer. With the sub-clock source, the slow tick comes every 500 ms. The fast tick then comes every 976 µs, 3.9 ms, 15.6 ms or 62.5 ms. The tone is 4 kHz or 2 kHz.

Each tick sets a sticky flag that software clears through a clear input. A per-flag enable gates the flag into a shared request line. That request line is also driven by an external interrupt input, because the two share one vector. Changing the source restarts the chain from zero, so the first period after a change is never short.

Top module: `base_tick_gen`

## Requirements
- R1: After reset, slow_flag, fast_flag, irq and buz_out are 0 and the divider count is zero.
- R2: src_sel selects what advances the divider. Code 0 is a sub_tick strobe, code 1 is every clock, code 2 is a pre_tick strobe, and code 3 stops the divider. Strobes from a source that is not selected have no effect.
- R3: slow_flag is set on the 16384th advance after the divider last restarted, and then every 16384 advances.
- R4: fast_flag is set on the 32nd, 128th, 512th or 2048th advance after a restart, for fast_sel codes 0, 1, 2 and 3.
- R5: slow_flag and fast_flag stay set until their clear input is high at a clock edge. The flag is 0 after that edge.
- R6: irq is high in the same cycle whenever (slow_flag and slow_ie), (fast_flag and fast_ie) or ext_req is high. It is low otherwise.
- R7: With buz_en high, buz_out is a square wave. With buz_sel 0 its period is 8 advances and it first goes high on the 4th advance after a restart. With buz_sel 1 its period is 16 advances and it first goes high on the 8th. With buz_en low, buz_out is 0.
- R8: A clock edge at which src_sel differs from the source in use resets the divider to zero without advancing it. All later periods count from that edge, even when the change happens part-way through a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 2 | Advance source: 0 sub-clock strobe, 1 every clock, 2 prescaler strobe, 3 stop |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period |
| pre_tick | input | 1 | One-cycle strobe from another timer's prescaler |
| fast_sel | input | 2 | Fast tick period: 32, 128, 512 or 2048 advances |
| slow_ie | input | 1 | Enables slow_flag onto irq |
| fast_ie | input | 1 | Enables fast_flag onto irq |
| slow_clr | input | 1 | Clears slow_flag |
| fast_clr | input | 1 | Clears fast_flag |
| ext_req | input | 1 | External interrupt request sharing the vector |
| buz_en | input | 1 | Tone enable |
| buz_sel | input | 1 | Tone select: 0 divide by 8, 1 divide by 16 |
| slow_flag | output | 1 | Sticky slow tick flag |
| fast_flag | output | 1 | Sticky fast tick flag |
| irq | output | 1 | Combined request |
| buz_out | output | 1 | Tone output |

## Verification
The flags are registered. Each flag is visible right after the edge that makes the Nth advance, where N is counted from the source-change edge, which itself never advances. The bench drives its inputs at falling edges, counts advances itself and checks the flag at every falling edge. A period is therefore measured as the exact count at which the flag first appears. The tone follows the count with no further register, so its rise is checked the same way. The irq output is combinational and is sampled a fraction of a cycle after its inputs change. A clear takes effect at the next rising edge and is checked at the falling edge after it.

// File: rtl/base_tick_gen.sv
module base_tick_gen #(
  parameter int CNT_W     = 14,
  parameter int FAST_LSB  = 5,
  parameter int FAST_STEP = 2,
  parameter int BUZ_TAP   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       sub_tick,
  input  logic       pre_tick,
  input  logic [1:0] fast_sel,
  input  logic       slow_ie,
  input  logic       fast_ie,
  input  logic       slow_clr,
  input  logic       fast_clr,
  input  logic       ext_req,
  input  logic       buz_en,
  input  logic       buz_sel,
  output logic       slow_flag,
  output logic       fast_flag,
  output logic       irq,
  output logic       buz_out
);

  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [1:0]       src_q;
  logic             src_chg;
  logic             adv;
  logic [CNT_W-1:0] fmask;
  logic             slow_evt;
  logic             fast_evt;

  assign src_chg = (src_sel != src_q);

  always_comb begin
    unique case (src_q)
      2'd0:    adv = sub_tick;
      2'd1:    adv = 1'b1;
      2'd2:    adv = pre_tick;
      default: adv = 1'b0;
    endcase
    if (src_chg) adv = 1'b0;
  end

  assign fmask    = (ONE << (FAST_LSB + FAST_STEP * int'(fast_sel))) - ONE;
  assign fast_evt = adv && ((cnt & fmask) == fmask);
  assign slow_evt = adv && (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      src_q <= 2'd0;
    end else if (src_chg) begin
      cnt   <= '0;
      src_q <= src_sel;
    end else if (adv) begin
      cnt   <= cnt + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_flag <= 1'b0;
      fast_flag <= 1'b0;
    end else begin
      if (slow_evt)      slow_flag <= 1'b1;
      else if (slow_clr) slow_flag <= 1'b0;
      if (fast_evt)      fast_flag <= 1'b1;
      else if (fast_clr) fast_flag <= 1'b0;
    end
  end

  assign irq     = (slow_flag & slow_ie) | (fast_flag & fast_ie) | ext_req;
  assign buz_out = buz_en & (buz_sel ? cnt[BUZ_TAP+1] : cnt[BUZ_TAP]);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> (cnt == '0));

  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == 2'd3 && !src_chg) |=> $stable(cnt));

  p_slow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_flag && !slow_clr) |=> slow_flag);

  p_fast_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_flag && !fast_clr) |=> fast_flag);

  p_slow_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_flag) |-> (cnt == '0));

  p_slow_with_fast_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_flag) |-> fast_flag);

  p_buz_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_chg && !adv && $stable(buz_en) && $stable(buz_sel)) |=> $stable(buz_out));

endmodule

// File: tb/base_tick_gen_test.sv
module base_tick_gen_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] src_sel = 2'd3, fast_sel = 0;
  logic sub_tick = 0, pre_tick = 0, slow_ie = 0, fast_ie = 0;
  logic slow_clr = 0, fast_clr = 0, ext_req = 0, buz_en = 0, buz_sel = 0;
  logic slow_flag, fast_flag, irq, buz_out;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  base_tick_gen uut (.*);

  // packed as {src, fast_sel, expected advances}
  localparam logic [19:0] VEC [6] = '{
    {2'd1, 2'd0, 16'd32},  {2'd0, 2'd1, 16'd128}, {2'd1, 2'd2, 16'd512},
    {2'd2, 2'd0, 16'd32},  {2'd1, 2'd3, 16'd2048}, {2'd2, 2'd1, 16'd128}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive the strobes for one cycle (sub on phase 0, pre on phase 1), return 1 if selected source advances
  task automatic step(input logic [1:0] src, input int ph, output bit advd);
    sub_tick = (ph % 3 == 0);
    pre_tick = (ph % 3 == 1);
    @(negedge clk);
    advd = (src == 2'd1) || (src == 2'd0 && ph % 3 == 0) || (src == 2'd2 && ph % 3 == 1);
  endtask

  // switch source (restart edge), then count advances until the chosen flag appears
  task automatic measure(input logic [1:0] src, input bit slow, output int n);
    bit advd;
    src_sel = src; fast_clr = 1; slow_clr = 1; sub_tick = 0; pre_tick = 0;
    @(negedge clk);
    fast_clr = 0; slow_clr = 0;
    n = 0;
    for (int i = 0; i < 70000; i++) begin
      step(src, i, advd);
      if (advd) n++;
      if (slow ? slow_flag : fast_flag) break;
    end
    sub_tick = 0; pre_tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    bit bad;
    repeat (3) @(negedge clk);
    chk(!slow_flag && !fast_flag && !irq && !buz_out, "R1 reset outputs", {slow_flag, fast_flag, irq, buz_out}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      fast_sel = VEC[k][17:16];
      measure(VEC[k][19:18], 1'b0, n);
      chk(n == int'(VEC[k][15:0]), $sformatf("R4/R2/R8 fast period src=%0d sel=%0d", VEC[k][19:18], VEC[k][17:16]), n, int'(VEC[k][15:0]));
    end

    measure(2'd1, 1'b1, n);
    chk(n == 16384, "R3 slow period", n, 16384);

    // R5/R6: sticky flags and request gating
    src_sel = 2'd3; fast_ie = 0; slow_ie = 0;
    repeat (10) @(negedge clk);
    chk(slow_flag && fast_flag, "R5 flags sticky", {slow_flag, fast_flag}, 3);
    chk(!irq, "R6 irq masked", irq, 0);
    fast_ie = 1; #1;
    chk(irq, "R6 irq from fast flag", irq, 1);
    fast_ie = 0; slow_ie = 1; #1;
    chk(irq, "R6 irq from slow flag", irq, 1);
    @(negedge clk); fast_clr = 1; @(negedge clk); fast_clr = 0;
    chk(!fast_flag && slow_flag, "R5 fast clear only", {slow_flag, fast_flag}, 2);
    slow_clr = 1; @(negedge clk); slow_clr = 0;
    chk(!slow_flag, "R5 slow clear", slow_flag, 0);
    chk(!irq, "R6 irq low after clear", irq, 0);
    ext_req = 1; #1;
    chk(irq, "R6 irq from ext_req", irq, 1);
    ext_req = 0; slow_ie = 0;

    // R2: code 3 stops the chain; strobes ignored
    fast_sel = 2'd0; buz_en = 1; bad = 0;
    for (int i = 0; i < 300; i++) begin
      bit a;
      step(2'd3, i, a);
      if (fast_flag || buz_out) bad = 1;
    end
    chk(!bad, "R2 stopped source", bad, 0);

    // R7: tone timing
    for (int s = 0; s < 2; s++) begin
      int rise, hi;
      buz_sel = s[0]; src_sel = 2'd1;
      @(negedge clk);
      rise = 0;
      for (int i = 1; i < 40; i++) begin @(negedge clk); if (buz_out) begin rise = i; break; end end
      chk(rise == (s ? 8 : 4), "R7 tone first rise", rise, s ? 8 : 4);
      hi = 0;
      while (buz_out && hi < 40) begin @(negedge clk); hi++; end
      chk(hi == (s ? 8 : 4), "R7 tone half period", hi, s ? 8 : 4);
      src_sel = 2'd3; @(negedge clk);
    end
    buz_en = 0; src_sel = 2'd1; bad = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (buz_out) bad = 1; end
    chk(!bad, "R7 tone disabled low", bad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule